// File: doc/BRIEF.md
# Alternating-Compare PWM Timer Channel

This block is one 16-bit timer channel that makes a pulse-width-modulated waveform by toggling an internal output flag each time the counter equals the compare register that is currently active. Two compare registers are used in turn. One sets how long the low phase lasts and the other sets how long the high phase lasts. Each compare register has a preload register. The preload of one compare register is copied in when the other compare register matches, so a new duty setting takes effect at a phase boundary and never in the middle of a phase. The counter advances only on cycles where an external prescaled tick input is high. It can count up or down, and it can reload from a load value on a match.

Software reaches the channel through a plain register bus: a write strobe, an address and data, and a combinational read port. Through it software programs the registers, forces the output flag, parks the channel at an idle level and clears sticky event flags. The pin stage can invert the flag and gates the pin with an output enable. An interrupt line is the OR of the event flags that are enabled.

Top module: `altcmp_pwm`

## Requirements
- R1: After reset, every readable register reads 0, pin_out is 0, pin_oe is 0 and irq is 0. The register addresses are 0 compare A, 1 compare B, 2 preload A, 3 preload B, 4 load value, 5 counter, 6 control, 7 pin control, 8 interrupt enable, 9 flags, 10 idle command.
- R2: In toggle mode with reload enabled, counting up from load value 0 with the tick held high, the pin stays low for (compare A + 1) cycles and high for (compare B + 1) cycles. Each match flips the flag and hands the comparison to the other compare register. Control bits: [1:0] count mode (0 stops the counter), [2] reload on match, [3] count down, [5:4] output mode (0 hold, 1 clear, 2 set, 3 toggle-alternating).
- R3: When compare A matches, preload B is copied into compare B. When compare B matches, preload A is copied into compare A. Running with compare A=2, compare B=4, preload A=6 and preload B=1 gives high phases of 2 cycles and low phases of 7 cycles.
- R4: In output mode 2 a match sets the flag. In output mode 1 a match clears the flag.
- R5: With reload enabled, a match reloads the counter from the load value. With reload disabled, the counter passes 0xFFFF and wraps to 0, and flag bit 1 (overflow) sets.
- R6: When counting down outside toggle mode, the counter is compared with compare B. A match with reload enabled loads the load value, and flag bit 3 (compare B) sets.
- R7: The counter changes only on cycles where tick_in is high and the count mode is non-zero.
- R8: Pin control bits: [0] output enable, [1] invert, [2] force value. A write with bit 3 set copies the force value into the flag. pin_out equals flag XOR invert while enabled and is 0 while disabled. pin_oe follows bit 0.
- R9: A write to the idle command stops the counter (count mode becomes 0) and clears the counter to 0. It also sets the flag so that pin_out shows data bit 0, whatever the invert setting.
- R10: Flag bits are [0] any compare, [1] overflow, [2] compare A, [3] compare B. Each bit is sticky and is cleared by writing 1 to it at address 9. If a flag sets and is cleared in the same cycle, the set wins.
- R11: irq is high exactly when some flag is set and its enable bit at address 8 (same bit order) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data for rd_addr (combinational) |
| tick_in | input | 1 | Prescaled count tick |
| pin_out | output | 1 | PWM pin after polarity and enable |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the handover of preloads in the middle of a run. Preload B has to land in compare B at the end of a low phase, and preload A has to land in compare A at the end of the following high phase. From the ports this shows up only as the lengths of later pulses. The stimulus parks the channel with an idle write, programs compares and preloads to different values, and restarts it with the tick held high. A scoreboard holds the expected phase levels and lengths, and a monitor measures each completed pulse on the pin and compares it with the next entry in the queue. Counter corner cases (reload, wrap at 0xFFFF, down-count reload, stalling) are reached with bursts of an exact number of ticks, followed by reading the counter back.

// File: rtl/altcmp_pkg.sv
package altcmp_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_CMPA  = 4'd0;
    localparam logic [REG_AW-1:0] A_CMPB  = 4'd1;
    localparam logic [REG_AW-1:0] A_PREA  = 4'd2;
    localparam logic [REG_AW-1:0] A_PREB  = 4'd3;
    localparam logic [REG_AW-1:0] A_LOAD  = 4'd4;
    localparam logic [REG_AW-1:0] A_CNT   = 4'd5;
    localparam logic [REG_AW-1:0] A_CTRL  = 4'd6;
    localparam logic [REG_AW-1:0] A_OUTC  = 4'd7;
    localparam logic [REG_AW-1:0] A_IEN   = 4'd8;
    localparam logic [REG_AW-1:0] A_FLAGS = 4'd9;
    localparam logic [REG_AW-1:0] A_IDLE  = 4'd10;

    localparam int NFLAG = 4;
    localparam int F_CMP = 0;
    localparam int F_OVF = 1;
    localparam int F_CA  = 2;
    localparam int F_CB  = 3;

    typedef enum logic [1:0] {
        OM_HOLD   = 2'd0,
        OM_CLEAR  = 2'd1,
        OM_SET    = 2'd2,
        OM_TOGGLE = 2'd3
    } omode_e;

    // control word: [1:0] mode, [2] reload, [3] down, [5:4] output mode
    typedef struct packed {
        omode_e     omode;
        logic       down;
        logic       len;
        logic [1:0] mode;
    } ctrl_t;

    // pin control: [0] enable, [1] invert, [2] force value
    typedef struct packed {
        logic fval;
        logic inv;
        logic oen;
    } outc_t;

endpackage

// File: rtl/altcmp_cfg.sv
module altcmp_cfg
    import altcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             outc_we,
    input  logic             ien_we,
    input  logic             idle_stb,
    input  logic [5:0]       wd,
    output ctrl_t            ctrl_o,
    output outc_t            outc_o,
    output logic [NFLAG-1:0] ien_o
);

    typedef struct packed {
        ctrl_t            ctrl;
        outc_t            outc;
        logic [NFLAG-1:0] ien;
    } cfg_st;

    cfg_st cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_we) cfg_d.ctrl = ctrl_t'(wd);
        if (outc_we) cfg_d.outc = outc_t'(wd[2:0]);
        if (ien_we)  cfg_d.ien  = wd[NFLAG-1:0];
        // parking the channel always stops counting
        if (idle_stb) cfg_d.ctrl.mode = 2'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ctrl_o = cfg_q.ctrl;
    assign outc_o = cfg_q.outc;
    assign ien_o  = cfg_q.ien;

endmodule

// File: rtl/altcmp_core.sv
module altcmp_core
    import altcmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  ctrl_t            ctrl,
    input  logic             we_cmpa,
    input  logic             we_cmpb,
    input  logic             we_prea,
    input  logic             we_preb,
    input  logic             we_load,
    input  logic             we_cnt,
    input  logic [CW-1:0]    wd,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic             force_stb,
    input  logic             force_val,
    input  logic             idle_stb,
    input  logic             idle_val,
    output logic [CW-1:0]    cnt_o,
    output logic [CW-1:0]    cmpa_o,
    output logic [CW-1:0]    cmpb_o,
    output logic [CW-1:0]    prea_o,
    output logic [CW-1:0]    preb_o,
    output logic [CW-1:0]    load_o,
    output logic             oflag_o,
    output logic [NFLAG-1:0] flags_o,
    output logic             hit_o
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    cmpa;
        logic [CW-1:0]    cmpb;
        logic [CW-1:0]    prea;
        logic [CW-1:0]    preb;
        logic [CW-1:0]    load;
        logic             oflag;
        logic             sel;
        logic [NFLAG-1:0] flags;
    } core_st;

    core_st st_d, st_q;

    logic          adv, tgl, use_b, hit, hit_a, hit_b, at_end, wrap;
    logic [CW-1:0] act;
    logic [NFLAG-1:0] ev;

    always_comb begin
        adv    = tick && (ctrl.mode != 2'd0);
        tgl    = (ctrl.omode == OM_TOGGLE);
        use_b  = tgl ? st_q.sel : ctrl.down;
        act    = use_b ? st_q.cmpb : st_q.cmpa;
        hit    = adv && (st_q.cnt == act);
        hit_a  = hit && !use_b;
        hit_b  = hit && use_b;
        at_end = ctrl.down ? (st_q.cnt == '0) : (st_q.cnt == CNT_MAX);
        wrap   = adv && at_end && !(hit && ctrl.len);

        ev        = '0;
        ev[F_CMP] = hit;
        ev[F_OVF] = wrap;
        ev[F_CA]  = hit_a;
        ev[F_CB]  = hit_b;

        st_d = st_q;

        if (adv) begin
            if (hit && ctrl.len) st_d.cnt = st_q.load;
            else if (ctrl.down)  st_d.cnt = st_q.cnt - 1'b1;
            else                 st_d.cnt = st_q.cnt + 1'b1;
        end

        // cross-triggered preload
        if (hit_a) st_d.cmpb = st_q.preb;
        if (hit_b) st_d.cmpa = st_q.prea;

        if (hit) begin
            unique case (ctrl.omode)
                OM_CLEAR:  st_d.oflag = 1'b0;
                OM_SET:    st_d.oflag = 1'b1;
                OM_TOGGLE: begin
                    st_d.oflag = !st_q.oflag;
                    st_d.sel   = !st_q.sel;
                end
                default:   st_d.oflag = st_q.oflag;
            endcase
        end

        // set beats clear
        st_d.flags = (st_q.flags & ~flag_clr) | ev;

        // bus writes take precedence over hardware updates
        if (we_cmpa) st_d.cmpa = wd;
        if (we_cmpb) st_d.cmpb = wd;
        if (we_prea) st_d.prea = wd;
        if (we_preb) st_d.preb = wd;
        if (we_load) st_d.load = wd;
        if (we_cnt)  st_d.cnt  = wd;

        if (force_stb) begin
            st_d.oflag = force_val;
            st_d.sel   = force_val;
        end

        if (idle_stb) begin
            st_d.cnt   = '0;
            st_d.oflag = idle_val;
            st_d.sel   = idle_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign cmpa_o  = st_q.cmpa;
    assign cmpb_o  = st_q.cmpb;
    assign prea_o  = st_q.prea;
    assign preb_o  = st_q.preb;
    assign load_o  = st_q.load;
    assign oflag_o = st_q.oflag;
    assign flags_o = st_q.flags;
    assign hit_o   = hit;

endmodule

// File: rtl/altcmp_pwm.sv
module altcmp_pwm
    import altcmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [CW-1:0]     rd_data,
    input  logic              tick_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq
);

    localparam int NREG = 1 << REG_AW;

    logic [NREG-1:0]  wdec;
    ctrl_t            cfg_ctrl;
    outc_t            cfg_outc;
    logic [NFLAG-1:0] cfg_ien;
    logic [CW-1:0]    core_cnt, core_cmpa, core_cmpb, core_prea, core_preb, core_load;
    logic             core_flag, core_hit;
    logic [NFLAG-1:0] core_flags;
    logic             force_stb, idle_stb, idle_val;
    logic [NFLAG-1:0] flag_clr;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_wdec
        assign wdec[gi] = wr_en && (wr_addr == REG_AW'(gi));
    end

    assign force_stb = wdec[A_OUTC] && wr_data[3];
    assign idle_stb  = wdec[A_IDLE];
    assign idle_val  = wr_data[0] ^ cfg_outc.inv;
    assign flag_clr  = wdec[A_FLAGS] ? wr_data[NFLAG-1:0] : '0;

    altcmp_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (wdec[A_CTRL]),
        .outc_we  (wdec[A_OUTC]),
        .ien_we   (wdec[A_IEN]),
        .idle_stb (idle_stb),
        .wd       (wr_data[5:0]),
        .ctrl_o   (cfg_ctrl),
        .outc_o   (cfg_outc),
        .ien_o    (cfg_ien)
    );

    altcmp_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_in),
        .ctrl      (cfg_ctrl),
        .we_cmpa   (wdec[A_CMPA]),
        .we_cmpb   (wdec[A_CMPB]),
        .we_prea   (wdec[A_PREA]),
        .we_preb   (wdec[A_PREB]),
        .we_load   (wdec[A_LOAD]),
        .we_cnt    (wdec[A_CNT]),
        .wd        (wr_data),
        .flag_clr  (flag_clr),
        .force_stb (force_stb),
        .force_val (wr_data[2]),
        .idle_stb  (idle_stb),
        .idle_val  (idle_val),
        .cnt_o     (core_cnt),
        .cmpa_o    (core_cmpa),
        .cmpb_o    (core_cmpb),
        .prea_o    (core_prea),
        .preb_o    (core_preb),
        .load_o    (core_load),
        .oflag_o   (core_flag),
        .flags_o   (core_flags),
        .hit_o     (core_hit)
    );

    always_comb begin
        unique case (rd_addr)
            A_CMPA:  rd_data = core_cmpa;
            A_CMPB:  rd_data = core_cmpb;
            A_PREA:  rd_data = core_prea;
            A_PREB:  rd_data = core_preb;
            A_LOAD:  rd_data = core_load;
            A_CNT:   rd_data = core_cnt;
            A_CTRL:  rd_data = CW'(cfg_ctrl);
            A_OUTC:  rd_data = CW'(cfg_outc);
            A_IEN:   rd_data = CW'(cfg_ien);
            A_FLAGS: rd_data = CW'(core_flags);
            default: rd_data = '0;
        endcase
    end

    assign pin_oe  = cfg_outc.oen;
    assign pin_out = cfg_outc.oen && (core_flag ^ cfg_outc.inv);
    assign irq     = |(core_flags & cfg_ien);

endmodule

// File: rtl/altcmp_sva.sv
module altcmp_sva
    import altcmp_pkg::*;
#(
    parameter int CW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic              tick_in,
    input logic [CW-1:0]     cnt_w,
    input logic [CW-1:0]     load_w,
    input logic              hit_w,
    input logic              flag_w,
    input logic [NFLAG-1:0]  flags_w,
    input ctrl_t             ctrl_w
);

    // R7: no tick and no bus write leaves the counter untouched
    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && !wr_en) |=> $stable(cnt_w));

    // R9: idle command zeroes the counter and the count mode
    a_r9_idle_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_IDLE) |=> (cnt_w == '0 && ctrl_w.mode == 2'd0));

    // R10: flags only fall through a flag write
    a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_FLAGS) |=> ((~flags_w & $past(flags_w)) == '0));

    // R5: a match with reload enabled lands the load value
    a_r5_reload_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w && ctrl_w.len && !wr_en) |=> (cnt_w == $past(load_w)));

    // R4: set-on-compare drives the flag high
    a_r4_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w && ctrl_w.omode == OM_SET && !wr_en) |=> flag_w);

    // R10: a match always raises the compare flag
    a_r10_match_flags: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w |=> flags_w[F_CMP]);

endmodule

bind altcmp_pwm altcmp_sva #(.CW(CW)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .tick_in (tick_in),
    .cnt_w   (core_cnt),
    .load_w  (core_load),
    .hit_w   (core_hit),
    .flag_w  (core_flag),
    .flags_w (core_flags),
    .ctrl_w  (cfg_ctrl)
);

// File: tb/tb_altcmp_pwm.sv
`timescale 1ns/1ps
module tb_altcmp_pwm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        tick_in = 1'b0;
    logic        pin_out, pin_oe, irq;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    altcmp_pwm dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_in(tick_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct {
        logic  lvl;
        int    len;
        string tag;
    } seg_t;

    seg_t sbq[$];
    logic mon_on = 1'b0;
    logic mon_init = 1'b0;
    logic mon_seen = 1'b0;
    logic mon_prev = 1'b0;
    int   mon_run = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_seg(logic lvl, int len, string tag);
        seg_t s;
        s.lvl = lvl; s.len = len; s.tag = tag;
        sbq.push_back(s);
    endtask

    // scoreboard monitor: measures completed pin phases
    always @(negedge clk) begin
        if (!mon_on) begin
            mon_init <= 1'b0;
        end else if (!mon_init) begin
            mon_init <= 1'b1;
            mon_seen <= 1'b0;
            mon_prev <= pin_out;
            mon_run  <= 1;
        end else if (pin_out == mon_prev) begin
            mon_run <= mon_run + 1;
        end else begin
            if (mon_seen && sbq.size() > 0) begin
                seg_t e;
                e = sbq.pop_front();
                n_chk++;
                if (mon_prev !== e.lvl || mon_run != e.len) begin
                    n_err++;
                    $display("FAIL %s actual=lvl%0d/len%0d expected=lvl%0d/len%0d",
                             e.tag, mon_prev, mon_run, e.lvl, e.len);
                end
            end
            mon_seen <= 1'b1;
            mon_prev <= pin_out;
            mon_run  <= 1;
        end
    end

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic pulse_ticks(int n);
        @(posedge clk); #1 tick_in = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_in = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
        mon_on = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            chk("R1 reg", 32'(v), 32'h0);
        end
        chk("R1 pin_out", 32'(pin_out), 0);
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 irq", 32'(irq), 0);

        // R2 plain toggle PWM: low 3, high 5
        wr(4'd7, 16'h0001);
        wr(4'd0, 16'd2); wr(4'd1, 16'd4);
        wr(4'd2, 16'd2); wr(4'd3, 16'd4);
        mon_on = 1'b1;
        wr(4'd6, 16'h0035);
        #1 tick_in = 1'b1;
        push_seg(1, 5, "R2 high"); push_seg(0, 3, "R2 low");
        push_seg(1, 5, "R2 high"); push_seg(0, 3, "R2 low");
        drain();

        // R3 cross-triggered preload: high 2, low 7
        wr(4'd10, 16'h0000);
        wr(4'd0, 16'd2); wr(4'd1, 16'd4);
        wr(4'd2, 16'd6); wr(4'd3, 16'd1);
        mon_on = 1'b1;
        wr(4'd6, 16'h0035);
        push_seg(1, 2, "R3 high"); push_seg(0, 7, "R3 low");
        push_seg(1, 2, "R3 high"); push_seg(0, 7, "R3 low");
        drain();

        // R4 set and clear on compare
        wr(4'd10, 16'h0000);
        wr(4'd0, 16'd3); wr(4'd2, 16'd3);
        wr(4'd6, 16'h0025);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk("R4 set mode pin", 32'(pin_out), 1);
        wr(4'd6, 16'h0015);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk("R4 clear mode pin", 32'(pin_out), 0);
        #1 tick_in = 1'b0;
        rd(4'd9, v);
        chk("R10 cmp and cmpA flags", 32'(v & 16'h5), 32'h5);

        // R10 write-one clear
        wr(4'd9, 16'h000F);
        rd(4'd9, v);
        chk("R10 flags cleared", 32'(v), 0);

        // R5 reload from load value
        wr(4'd10, 16'h0000);
        wr(4'd4, 16'h0010); wr(4'd0, 16'h0012); wr(4'd2, 16'h0012);
        wr(4'd6, 16'h0005);
        pulse_ticks(20);
        rd(4'd5, v);
        chk("R5 reload count", 32'(v), 32'h11);

        // R5 wrap without reload
        wr(4'd9, 16'h000F);
        wr(4'd6, 16'h0001);
        wr(4'd5, 16'hFFFE);
        pulse_ticks(3);
        rd(4'd5, v);
        chk("R5 wrap count", 32'(v), 32'h1);
        rd(4'd9, v);
        chk("R5 overflow flag", 32'(v[1]), 1);

        // R11 interrupt enable
        chk("R11 irq masked", 32'(irq), 0);
        wr(4'd8, 16'h0002);
        @(negedge clk);
        chk("R11 irq enabled", 32'(irq), 1);
        wr(4'd9, 16'h0002);
        @(negedge clk);
        chk("R11 irq after clear", 32'(irq), 0);

        // R7 stall conditions
        wr(4'd6, 16'h0000);
        pulse_ticks(5);
        rd(4'd5, v);
        chk("R7 mode zero", 32'(v), 32'h1);
        wr(4'd6, 16'h0001);
        repeat (5) @(posedge clk);
        rd(4'd5, v);
        chk("R7 tick low", 32'(v), 32'h1);
        pulse_ticks(2);
        rd(4'd5, v);
        chk("R7 two ticks", 32'(v), 32'h3);

        // R6 down count against compare B
        wr(4'd9, 16'h000F);
        wr(4'd1, 16'd5); wr(4'd4, 16'd8); wr(4'd5, 16'd7);
        wr(4'd6, 16'h000D);
        pulse_ticks(4);
        rd(4'd5, v);
        chk("R6 down reload", 32'(v), 32'h7);
        rd(4'd9, v);
        chk("R6 cmpB flag", 32'(v[3]), 1);

        // R8 force and polarity
        wr(4'd6, 16'h0000);
        wr(4'd7, 16'h000D);
        @(negedge clk);
        chk("R8 force high", 32'(pin_out), 1);
        wr(4'd7, 16'h0003);
        @(negedge clk);
        chk("R8 inverted", 32'(pin_out), 0);
        wr(4'd7, 16'h0000);
        @(negedge clk);
        chk("R8 disabled pin", 32'(pin_out), 0);
        chk("R8 disabled oe", 32'(pin_oe), 0);
        wr(4'd7, 16'h0009);
        @(negedge clk);
        chk("R8 force low", 32'(pin_out), 0);

        // R9 idle with inverted polarity
        wr(4'd7, 16'h0003);
        wr(4'd6, 16'h0001);
        wr(4'd5, 16'h0044);
        wr(4'd10, 16'h0001);
        @(negedge clk);
        chk("R9 idle high", 32'(pin_out), 1);
        rd(4'd5, v);
        chk("R9 count zero", 32'(v), 0);
        rd(4'd6, v);
        chk("R9 mode stopped", 32'(v[1:0]), 0);
        wr(4'd10, 16'h0000);
        @(negedge clk);
        chk("R9 idle low", 32'(pin_out), 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule